// File: doc/BRIEF.md
# I2C Target with Command Pointer

This block is the serial front end of a small register-mapped peripheral that sits on a two-wire I2C bus. A fast system clock oversamples SCL and SDA. The block finds START, repeated START and STOP conditions on the oversampled lines. It answers one fixed 7-bit address and pulls SDA low (open-drain) for its acknowledge bits and for the zero bits of read data. Behind it sits a bank of up to four byte-wide registers, reached through a plain pointer and strobe interface.

In a write transaction, the first byte after the address is a command byte, and it becomes the register pointer. Every later data byte in the same transaction goes to the register that pointer selects, because the pointer never advances on its own. A read transaction returns the selected register for as many bytes as the controller acknowledges. A controller that reads with no command byte gets the pointer left by the last command. The register side has no back-pressure, since the block never stretches the clock. The bank must present `reg_rdata` combinationally from `reg_sel` in the cycle that `reg_rd` is high, and it must take `reg_wdata` in the cycle that `reg_wr` is high.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), `reg_sel` is 0, and neither strobe is active.
- R2: An address byte is acknowledged only when its upper seven bits equal 1000001 (write byte 0x82, read byte 0x83). After any other address, SDA stays released and no strobe fires until the next START, even if more bytes follow.
- R3: In a write transaction, the first byte after the address is acknowledged and stored as the pointer. `reg_sel` shows its low two bits from then on.
- R4: Each data byte that follows the command is acknowledged and produces exactly one single-cycle `reg_wr`. The pulse carries the received byte on `reg_wdata` and comes during that byte's acknowledge clock.
- R5: The pointer does not advance. Every data byte of a burst goes to the same register, and only a new command byte changes the pointer.
- R6: After a matching read address, every byte is loaded with one `reg_rd` pulse and shifted out MSB first. A controller ACK causes the same register to be read again. A controller NACK ends the transfer, and SDA stays released.
- R7: A read that is not preceded by a command byte in the same transaction uses the stored pointer. The pointer survives STOP, and its reset value is 0.
- R8: A command value of 4 or more is acknowledged but selects nothing. Data bytes written to it are acknowledged with no `reg_wr`, and reads from it return 0xFF with no `reg_rd`.
- R9: A STOP at any byte boundary returns the block to idle. A STOP right after the address or after the command byte leaves the pointer unchanged.
- R10: A repeated START restarts address reception at once, whether it comes after a command byte or after a data byte.
- R11: `sda_oe` changes only while SCL is low.
- R12: The block works at any SCL rate whose high and low phases each last at least 8 system clocks. This covers 0 to 400 kHz at a 125 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| reg_sel | output | SEL_W (2) | Register pointer from the last command byte |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_rdata | input | 8 | Read data from the bank, sampled while `reg_rd` is high |

## Verification
The hardest state to reach is the one where the block ignores the bus after an address that does not match. The only sign of this state is what the block fails to do. To reach it, the stimulus sweeps all 128 write addresses. After each mismatch it sends a byte that would be a valid command if it were accepted. The test then checks that this byte gets no ACK, that no write strobe appears and that `reg_sel` does not change. A second hard case is a read that relies on a pointer kept across STOP. It is reached with a transaction that carries only a command byte, followed by a fresh read-only transaction.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  // value returned when the pointer selects no register
  localparam logic [BYTE_W-1:0] RD_FILL = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  // one more stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high are bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'b1000001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_req,
  output logic              rd_req,
  output logic              cmd_load,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int          CNT_W     = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_t        state_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              rw_q;
  logic              more_q;
  logic              sda_oe_q;
  logic              byte_done;
  logic              addr_hit;

  assign byte_done = scl_fall && (bitcnt_q == BITS_FULL);
  assign addr_hit  = (shreg_q[BYTE_W-1:1] == TGT_ADDR);

  assign wr_req   = (state_q == ST_WR) && byte_done;
  assign cmd_load = (state_q == ST_CMD) && byte_done;
  assign rd_req   = scl_fall && (((state_q == ST_ADDR_ACK) && rw_q) ||
                                 ((state_q == ST_RD_ACK) && more_q));
  assign rx_byte  = shreg_q;
  assign sda_oe   = sda_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      rw_q     <= 1'b0;
      more_q   <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      sda_oe_q <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise && (bitcnt_q < BITS_FULL)) begin
            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            bitcnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                sda_oe_q <= 1'b1;
                rw_q     <= shreg_q[0];
                state_q  <= ST_ADDR_ACK;
              end else begin
                state_q  <= ST_IDLE;
              end
            end else if (state_q == ST_CMD) begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_CMD_ACK;
            end else begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              shreg_q  <= rd_byte;
              sda_oe_q <= ~rd_byte[BYTE_W-1];
              bitcnt_q <= '0;
              state_q  <= ST_RD;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt_q == BITS_LAST) begin
              sda_oe_q <= 1'b0;
              bitcnt_q <= '0;
              state_q  <= ST_RD_ACK;
            end else begin
              shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~shreg_q[BYTE_W-2];
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            more_q <= ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              shreg_q  <= rd_byte;
              sda_oe_q <= ~rd_byte[BYTE_W-1];
              bitcnt_q <= '0;
              state_q  <= ST_RD;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !scl_s);

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_q);

  // R4
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R6
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (state_q == ST_RD));

endmodule

// File: rtl/i2c_cmd_ptr.sv
module i2c_cmd_ptr
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] bank_rdata,
  output logic [SEL_W-1:0]  reg_sel,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd,
  output logic [BYTE_W-1:0] rd_byte
);

  localparam logic [BYTE_W-1:0] REG_LIMIT = BYTE_W'(NUM_REGS);

  logic [BYTE_W-1:0] cmd_q;
  logic              sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (cmd_load) cmd_q <= rx_byte;
  end

  assign sel_ok    = (cmd_q < REG_LIMIT);
  assign reg_sel   = cmd_q[SEL_W-1:0];
  assign reg_wr    = wr_req & sel_ok;
  assign reg_wdata = rx_byte;
  assign reg_rd    = rd_req & sel_ok;
  assign rd_byte   = sel_ok ? bank_rdata : RD_FILL;

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_load |=> $stable(cmd_q));

endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'b1000001,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2,
  localparam int        SEL_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [SEL_W-1:0] reg_sel,
  output logic             reg_wr,
  output logic [7:0]       reg_wdata,
  output logic             reg_rd,
  input  logic [7:0]       reg_rdata
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_req, rd_req, cmd_load;
  logic [BYTE_W-1:0] rx_byte, rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .cmd_load  (cmd_load),
    .rx_byte   (rx_byte)
  );

  i2c_cmd_ptr #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_load   (cmd_load),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .rx_byte    (rx_byte),
    .bank_rdata (reg_rdata),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .rd_byte    (rd_byte)
  );

endmodule

// File: tb/sim_i2c_cmd_target.sv
module sim_i2c_cmd_target;

  localparam logic [7:0] ADDR_W = 8'h82;
  localparam logic [7:0] ADDR_R = 8'h83;
  localparam logic [7:0] IN_VAL = 8'h9C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl_low = 1'b0;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic [1:0] reg_sel;
  logic reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  wire scl_line = ~m_scl_low;
  wire sda_line = ~(m_sda_low | sda_oe);

  i2c_cmd_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // register bank model: register 0 is a read-only input value
  logic [7:0] bank [0:3];
  int wr_count = 0, rd_count = 0;
  logic [1:0] last_sel;
  logic [7:0] last_wdata;
  assign reg_rdata = bank[reg_sel];
  always @(posedge clk) begin
    if (!rst_n) begin
      bank[0] <= IN_VAL; bank[1] <= 8'hFF; bank[2] <= 8'h00; bank[3] <= 8'hFF;
    end else begin
      if (reg_wr) begin
        wr_count   <= wr_count + 1;
        last_sel   <= reg_sel;
        last_wdata <= reg_wdata;
        if (reg_sel != 2'd0) bank[reg_sel] <= reg_wdata;
      end
      if (reg_rd) rd_count <= rd_count + 1;
    end
  end

  int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;
  int half = 8;
  logic oe_prev = 1'b0;

  // R11: SDA drive may only change while SCL is low
  always @(negedge clk) begin
    if (rst_n && (oe_prev !== sda_oe)) begin
      mon_checks = mon_checks + 1;
      if (scl_line) begin
        mon_errors = mon_errors + 1;
        $display("FAIL R11 sda_oe changed with SCL high actual=%0b expected=%0b", sda_oe, oe_prev);
      end
    end
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic ph();
    repeat (half) @(negedge clk);
  endtask

  task automatic qw();
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; ph();
    m_scl_low = 1'b0; ph();
    m_sda_low = 1'b1; ph();
    m_scl_low = 1'b1; qw();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; ph();
    m_scl_low = 1'b0; ph();
    m_sda_low = 1'b0; ph(); ph();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; ph();
      m_scl_low = 1'b0; ph();
      m_scl_low = 1'b1; qw();
    end
    m_sda_low = 1'b0; ph();
    m_scl_low = 1'b0; ph();
    acked = ~sda_line;
    m_scl_low = 1'b1; qw();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      ph();
      m_scl_low = 1'b0; ph();
      b[i] = sda_line;
      m_scl_low = 1'b1; qw();
    end
    m_sda_low = ack; ph();
    m_scl_low = 1'b0; ph();
    m_scl_low = 1'b1; qw();
    m_sda_low = 1'b0;
  endtask

  function automatic logic [7:0] pat(int c, int p);
    return 8'((c * 37 + p * 91) ^ 8'h5A);
  endfunction

  logic [7:0] exp_reg [0:3];

  // read n bytes (last one NACKed) after a plain read address; checks data
  task automatic read_burst(input int n, input logic [7:0] want, input string req);
    logic [7:0] got;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, got);
      chk(got == want, req, got, want);
    end
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int wc0, rc0;

    exp_reg[0] = IN_VAL; exp_reg[1] = 8'hFF; exp_reg[2] = 8'h00; exp_reg[3] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(reg_sel == 2'd0, "R1 reg_sel", reg_sel, 0);
    chk(!reg_wr && !reg_rd, "R1 strobes", {reg_wr, reg_rd}, 0);

    // R2: sweep all write addresses
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk(ack == (a == 7'h41), "R2 address ack", ack, (a == 7'h41));
      if (a != 7'h41) begin
        send_byte(8'h03, ack);
        chk(!ack, "R2 ignored byte after mismatch", ack, 0);
      end
      bus_stop();  // R9: stop after address alone
    end
    chk(reg_sel == 2'd0, "R2 pointer untouched", reg_sel, 0);
    chk(wr_count == 0, "R2 no writes", wr_count, 0);

    // R2/R7: read addresses, pointer at reset value 0
    for (int j = 0; j < 5; j++) begin
      logic [6:0] ra;
      ra = (j == 0) ? 7'h40 : (j == 1) ? 7'h42 : (j == 2) ? 7'h01 : (j == 3) ? 7'h61 : 7'h41;
      rc0 = rd_count;
      bus_start();
      send_byte({ra, 1'b1}, ack);
      chk(ack == (ra == 7'h41), "R2 read address ack", ack, (ra == 7'h41));
      recv_byte(1'b1, d);
      chk(d == ((ra == 7'h41) ? IN_VAL : 8'hFF), "R7 read with reset pointer", d,
          (ra == 7'h41) ? IN_VAL : 8'hFF);
      chk(rd_count == rc0 + ((ra == 7'h41) ? 1 : 0), "R2 read strobe count", rd_count - rc0,
          (ra == 7'h41) ? 1 : 0);
      bus_stop();
    end

    // R3/R4/R5/R8: write sweep over commands and data patterns
    for (int c = 0; c < 6; c++) begin
      for (int p = 0; p < 4; p++) begin
        bus_start();
        send_byte(ADDR_W, ack);
        chk(ack, "R2 write address ack", ack, 1);
        send_byte(8'(c), ack);
        chk(ack, "R3 command ack", ack, 1);
        chk(reg_sel == 2'(c), "R3 pointer", reg_sel, 2'(c));
        for (int k = 0; k < 3; k++) begin
          d = (k == 0) ? pat(c, p) : (k == 1) ? ~pat(c, p) : 8'(pat(c, p) + 1);
          wc0 = wr_count;
          send_byte(d, ack);
          chk(ack, "R4 data ack", ack, 1);
          if (c < 4) begin
            chk(wr_count == wc0 + 1, "R4 one strobe per byte", wr_count - wc0, 1);
            chk(last_sel == 2'(c), "R5 burst stays on register", last_sel, c);
            chk(last_wdata == d, "R4 write data", last_wdata, d);
            if (c != 0) exp_reg[c] = d;
          end else begin
            chk(wr_count == wc0, "R8 out-of-range write ignored", wr_count - wc0, 0);
          end
        end
        bus_stop();
      end
    end

    // R6/R8/R10: read sweep with repeated START
    for (int c = 0; c < 6; c++) begin
      bus_start();
      send_byte(ADDR_W, ack);
      send_byte(8'(c), ack);
      bus_start();
      send_byte(ADDR_R, ack);
      chk(ack, "R10 read address after repeated start", ack, 1);
      rc0 = rd_count;
      read_burst(3, (c < 4) ? exp_reg[c] : 8'hFF, (c < 4) ? "R6 read data" : "R8 read fill");
      chk(rd_count == rc0 + ((c < 4) ? 3 : 0), "R6 read strobes", rd_count - rc0, (c < 4) ? 3 : 0);
      chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
      bus_stop();
    end

    // R7/R9: command-only transaction, then bare reads
    bus_start(); send_byte(ADDR_W, ack); send_byte(8'd2, ack); bus_stop();
    bus_start(); send_byte(ADDR_R, ack);
    read_burst(2, exp_reg[2], "R7 stored pointer read");
    bus_stop();
    bus_start(); send_byte(ADDR_W, ack); bus_stop();
    bus_start(); send_byte(ADDR_R, ack);
    read_burst(1, exp_reg[2], "R9 pointer kept after address-only write");
    bus_stop();

    // R10: repeated START after a data byte
    bus_start(); send_byte(ADDR_W, ack); send_byte(8'd3, ack); send_byte(8'h77, ack);
    bus_start(); send_byte(ADDR_W, ack);
    chk(ack, "R10 address after repeated start", ack, 1);
    send_byte(8'd1, ack); send_byte(8'h12, ack); bus_stop();
    exp_reg[3] = 8'h77; exp_reg[1] = 8'h12;
    bus_start(); send_byte(ADDR_W, ack); send_byte(8'd3, ack);
    bus_start(); send_byte(ADDR_R, ack);
    read_burst(1, exp_reg[3], "R10 first register");
    bus_stop();
    bus_start(); send_byte(ADDR_W, ack); send_byte(8'd1, ack);
    bus_start(); send_byte(ADDR_R, ack);
    read_burst(1, exp_reg[1], "R10 second register");
    bus_stop();

    // R12: slow bus
    half = 120;
    bus_start(); send_byte(ADDR_W, ack); send_byte(8'd2, ack); send_byte(8'hC3, ack);
    chk(ack, "R12 slow write ack", ack, 1);
    bus_start(); send_byte(ADDR_R, ack);
    read_burst(2, 8'hC3, "R12 slow read");
    bus_stop();
    half = 8;

    checks = checks + mon_checks;
    errors = errors + mon_errors;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1,
             errors + mon_errors + 1);
    $finish;
  end

endmodule